// File: doc/BRIEF.md
# Serial Port Queue Status and Interrupt Unit

This block sits beside the transmit and receive queues of a serial port and turns their fill levels and the engine's event pulses into status flags and one interrupt line. For each queue it derives an empty flag, a threshold flag and a full flag. The threshold flag compares the fill level with a watermark that software programs for that queue. It also reports whether a transfer is running and whether data was lost, through one error flag that merges receive overflow and transmit underflow.

Each of the eight status conditions feeds one sticky interrupt bit. A rising edge of the condition sets the bit. Software clears it by writing 1 to the matching bit of a clear register. A per-bit enable mask decides which sticky bits drive the single combined interrupt output. The queue storage and the serial engine are outside this block. It sees only their levels and pulses, and it offers a simple write port and a combinational read port.

Top module: `spi_qstat_irq`

## Requirements
- R1: A queue's empty flag is 1 exactly when its level is 0, and its full flag is 1 exactly when its level equals DEPTH (default 16).
- R2: A queue's threshold flag is 1 when its level is greater than or equal to that queue's watermark. The watermarks reset to DEPTH/2 and are written at address 4 (transmit) and address 5 (receive). The watermarks read back at the same addresses, and the live levels read at address 6 (transmit) and address 7 (receive).
- R3: The status word at address 0 holds, from bit 0 up: busy, error, tx empty, tx threshold, tx full, rx empty, rx threshold, rx full.
- R4: A one-cycle pulse on rx_overflow or tx_underflow sets the error flag from the next cycle on. The flag stays set until a write to the clear register has bit 1 set.
- R5: Interrupt status bit i (read at address 2) is set one clock after status bit i rises, and it then stays set until it is cleared.
- R6: irq is 1 exactly when some interrupt status bit and its enable bit (address 1, reset 0) are both 1.
- R7: Writing to address 3 clears every interrupt status bit written as 1. Bits written as 0 are unaffected, and a read of address 3 returns 0.
- R8: If a rising condition and a clear hit the same bit in the same cycle, the bit stays set.
- R9: After reset, with both queues empty and the port idle, the status reads 0x24, the interrupt status reads 0, irq is 0, and the two empty flags raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | LW | Transmit queue occupancy |
| rx_level | input | LW | Receive queue occupancy |
| busy | input | 1 | Transfer in progress, from the engine |
| rx_overflow | input | 1 | Receive overflow event pulse |
| tx_underflow | input | 1 | Transmit underflow event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the embedded properties check the following: a sticky bit falls only when a clear names it, a rising condition always leaves its bit set, the error flag persists until it is cleared, full and empty never coincide, and irq never rises without an enabled bit. Only the directed scenarios can show the rest. These cover the exact bit layout of the status word, the threshold comparison at watermark values the scenarios choose, the one-clock delay from condition to sticky bit, and the effect of writing zeros to the clear register. They also cover the collision between a clear and a new edge on the same bit, as seen through the read port.

// File: rtl/spi_qstat_irq.sv
module spi_qstat_irq #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          busy,
  input  logic          rx_overflow,
  input  logic          tx_underflow,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] WM_RST   = LW'(DEPTH / 2);
  localparam logic [7:0]    COND_RST = 8'h24;

  logic [LW-1:0] tx_wm, rx_wm;
  logic [7:0]    ien, ist, cond, cond_q, set_mask, clr_mask;
  logic          err_q;

  assign cond = {rx_level == FULL_LVL, rx_level >= rx_wm, rx_level == '0,
                 tx_level == FULL_LVL, tx_level >= tx_wm, tx_level == '0,
                 err_q, busy};

  assign set_mask = cond & ~cond_q;
  assign clr_mask = (wr_en && wr_addr == 3'd3) ? wr_data[7:0] : 8'h00;
  assign irq      = |(ist & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wm  <= WM_RST;
      rx_wm  <= WM_RST;
      ien    <= '0;
      ist    <= '0;
      cond_q <= COND_RST;
      err_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      ist    <= (ist & ~clr_mask) | set_mask;
      if (rx_overflow || tx_underflow) err_q <= 1'b1;
      else if (clr_mask[1])            err_q <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          3'd1:    ien   <= wr_data[7:0];
          3'd4:    tx_wm <= wr_data[LW-1:0];
          3'd5:    rx_wm <= wr_data[LW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = DW'(cond);
      3'd1:    rd_data = DW'(ien);
      3'd2:    rd_data = DW'(ist);
      3'd4:    rd_data = DW'(tx_wm);
      3'd5:    rd_data = DW'(rx_wm);
      3'd6:    rd_data = DW'(tx_level);
      3'd7:    rd_data = DW'(rx_level);
      default: rd_data = '0;
    endcase
  end

  p_full_not_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cond[4] && cond[2]) && !(cond[7] && cond[5]));

  p_error_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_mask[1]) |=> err_q);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ist) & ~$past(clr_mask)) & ~ist) == 8'h00);

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != 8'h00 && ist != 8'h00));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != 8'h00) |=> ((ist & $past(set_mask)) == $past(set_mask)));

endmodule

// File: tb/spi_qstat_irq_bench.sv
module spi_qstat_irq_bench;
  logic       clk = 0, rst_n = 0;
  logic [4:0] tx_level = 0, rx_level = 0;
  logic       busy = 0, rx_overflow = 0, tx_underflow = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       irq;
  int checks = 0, failures = 0;

  spi_qstat_irq u_spi_qstat_irq (.*);

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [7:0] exp, input string req);
    rd_addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s addr %0d actual=%h expected=%h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  task automatic t_reset();
    chk_reg(0, 8'h24, "R9");
    chk_reg(2, 8'h00, "R9");
    chk_irq(0, "R9");
    chk_reg(4, 8'h08, "R2");
    chk_reg(1, 8'h00, "R6");
  endtask

  task automatic t_levels();
    tx_level = 16; rx_level = 3;
    step();
    chk_reg(0, 8'h18, "R1 R3");
    chk_reg(2, 8'h18, "R5");
    chk_reg(6, 8'd16, "R2");
    chk_reg(7, 8'd3, "R2");
  endtask

  task automatic t_watermark();
    wr(5, 8'd3);
    chk_reg(5, 8'd3, "R2");
    chk_reg(0, 8'h58, "R2");
    step();
    chk_reg(2, 8'h58, "R5");
  endtask

  task automatic t_clear();
    wr(3, 8'h08);
    chk_reg(2, 8'h50, "R7");
    wr(3, 8'h00);
    chk_reg(2, 8'h50, "R7");
    chk_reg(3, 8'h00, "R7");
    chk_irq(0, "R6");
    wr(1, 8'h10);
    chk_irq(1, "R6");
    wr(3, 8'h10);
    chk_reg(2, 8'h40, "R7");
    chk_irq(0, "R6");
  endtask

  task automatic t_error();
    rx_overflow = 1; step(); rx_overflow = 0;
    chk_reg(0, 8'h5A, "R4");
    chk_reg(2, 8'h40, "R5");
    step();
    chk_reg(2, 8'h42, "R5");
    repeat (4) step();
    chk_reg(0, 8'h5A, "R4");
    wr(3, 8'h02);
    chk_reg(0, 8'h58, "R4");
    chk_reg(2, 8'h40, "R7");
    tx_underflow = 1; step(); tx_underflow = 0;
    step();
    chk_reg(2, 8'h42, "R4");
    wr(3, 8'h02);
    chk_reg(0, 8'h58, "R4");
  endtask

  task automatic t_collision();
    wr(1, 8'h01);
    busy = 1; step();
    chk_reg(2, 8'h41, "R5");
    chk_irq(1, "R6");
    busy = 0; step();
    chk_reg(2, 8'h41, "R5");
    busy = 1;
    wr(3, 8'h01);
    chk_reg(2, 8'h41, "R8");
    chk_irq(1, "R8");
    busy = 0;
    wr(3, 8'h01);
    chk_reg(2, 8'h40, "R7");
    chk_irq(0, "R6");
  endtask

  task automatic t_boundaries();
    tx_level = 15; step();
    chk_reg(0, 8'h48, "R1");
    wr(4, 8'd16);
    chk_reg(0, 8'h40, "R2");
    rx_level = 0; step();
    chk_reg(0, 8'h20, "R1");
    chk_reg(2, 8'h60, "R5");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_levels();
    t_watermark();
    t_clear();
    t_error();
    t_collision();
    t_boundaries();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule